// File: doc/BRIEF.md
# JTAG Chain Host Shift Engine

This block is the master side of a JTAG scan chain. It produces the scan clock from the system clock, drives the mode-select and serial-data lines that go into the chain, and samples the serial data that comes back. Software or a sequencer above it issues one command at a time over a valid/ready handshake. The three operations are: return every TAP in the chain to Test-Logic-Reset, load the concatenated instruction registers of all devices, or shift the selected data registers. Each shift command carries a bit count and a payload. The engine walks the TAPs to the right shift state and sends the payload least significant bit first. It raises the mode line together with the final data bit, passes through Update, and parks in Run-Test/Idle. It then returns the bits captured from the chain in a single response beat.

The instruction chain is as long as the sum of the instruction register lengths of the devices. With a 5-bit and a 10-bit device that is one 15-bit command. The low payload bits are meant for the device nearest the chain's output, because they are shifted in first. The engine remembers whether the chain was last left in Test-Logic-Reset or in Run-Test/Idle and shortens the entry walk to match.

The controller has five states. ST_IDLE accepts a command: a reset op moves it to ST_RESET and a shift op moves it to ST_ENTER. ST_RESET holds mode high for five scan cycles and then returns to ST_IDLE. ST_ENTER plays the entry walk and moves to ST_SHIFT. ST_SHIFT sends one payload bit per scan cycle and moves to ST_EXIT after the last bit. ST_EXIT plays mode 1 then 0 and returns to ST_IDLE. Every state change other than leaving ST_IDLE happens at a falling scan-clock edge.

Top module: `jtag_chain_host`

## Requirements
- R1: `cmd_ready` is high exactly when no command is in progress. An accepted command raises `busy` on the next clock. `cmd_valid` has no effect while `busy` is high. `busy` stays high until the clock in which `rsp_valid` pulses for one cycle, and it falls in that same clock.
- R2: `scan_clk_o` is low whenever `busy` is low. While a command runs, every scan-clock high or low phase lasts exactly HALF_DIV system clocks, and HALF_DIV must be at least 2.
- R3: `scan_mode_o` and `scan_out_o` change only while `scan_clk_o` is low, and never in the clock where it rises. `scan_in_i` is sampled in the clock where `scan_clk_o` rises.
- R4: Op code 2'b00 (reset) gives exactly five scan cycles with mode high and no other cycles. Every TAP then sits in Test-Logic-Reset, whatever state it started in, and the response data is zero.
- R5: Op code 2'b01 (instruction shift) enters Shift-IR with mode 0,1,1,0,0 when the chain was left in Test-Logic-Reset, and with 1,1,0,0 when it was left in Run-Test/Idle.
- R6: Op codes 2'b10 and 2'b11 (data shift) enter Shift-DR with mode 0,1,0,0 from Test-Logic-Reset and with 1,0,0 from Run-Test/Idle.
- R7: Payload bit 0 is sent first. Exactly the effective length of bits is shifted, and mode is high only on the last one. The chain register therefore ends holding the last bits sent.
- R8: Response bit i is the chain output sampled on the i-th shift cycle. Response bits at or above the effective length are zero.
- R9: After the last shift bit the engine plays mode 1 then 0, so the chain passes Update and parks in Run-Test/Idle with the scan clock low.
- R10: When more bits are shifted than a chain of length L holds, response bit i for i at or above L equals payload bit i-L.
- R11: A `cmd_len` of 0 shifts one bit, and a `cmd_len` above MAX_BITS shifts MAX_BITS bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken this clock if valid |
| cmd_op | input | 2 | 00 reset, 01 instruction shift, 10/11 data shift |
| cmd_len | input | LEN_W | Number of bits to shift |
| cmd_data | input | MAX_BITS | Payload, bit 0 sent first |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | MAX_BITS | Bits captured from the chain, bit 0 first |
| busy | output | 1 | Command in progress |
| scan_clk_o | output | 1 | Scan clock to the chain |
| scan_mode_o | output | 1 | Mode select to every TAP |
| scan_out_o | output | 1 | Serial data into the chain |
| scan_in_i | input | 1 | Serial data out of the chain |

## Verification
The bench builds the engine with MAX_BITS = 24 and HALF_DIV = 3. The odd divider makes a phase that is one clock too short or too long visible. The 24-bit payload exceeds both the 15-bit instruction chain and the 12-bit data chain of the bench's two-device TAP model, so over-length shifts and the delayed return of payload bits can be reached. A 5-bit length field with only 24 legal lengths also brings the clamp of lengths 25 to 31, and of length 0, within reach.

// File: rtl/jtag_chain_host_pkg.sv
package jtag_chain_host_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_IR    = 2'b01,
        OP_DR    = 2'b10,
        OP_DR_B  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_ENTER,
        ST_SHIFT,
        ST_EXIT
    } st_e;

    localparam int RESET_CYCLES = 5;

endpackage

// File: rtl/jtag_chain_host_div.sv
module jtag_chain_host_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_DIV - 1);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/jtag_chain_host_walk.sv
module jtag_chain_host_walk (
    input  logic       is_ir,
    input  logic       from_reset,
    output logic [4:0] walk_bits,
    output logic [2:0] walk_len
);
    logic [4:0] base_bits;
    logic [2:0] base_len;

    always_comb begin
        // From Run-Test/Idle: IR needs 1,1,0,0 and DR needs 1,0,0 (bit 0 first).
        base_bits = is_ir ? 5'b00011 : 5'b00001;
        base_len  = is_ir ? 3'd4 : 3'd3;
        if (from_reset) begin
            // A leading 0 moves Test-Logic-Reset to Run-Test/Idle first.
            walk_bits = {base_bits[3:0], 1'b0};
            walk_len  = base_len + 3'd1;
        end else begin
            walk_bits = base_bits;
            walk_len  = base_len;
        end
    end
endmodule

// File: rtl/jtag_chain_host_cap.sv
module jtag_chain_host_cap #(
    parameter int MAX_BITS = 32,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                sample,
    input  logic [IDX_W-1:0]    idx,
    input  logic                bit_in,
    output logic [MAX_BITS-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (clear) begin
            data <= '0;
        end else if (sample) begin
            data[idx] <= bit_in;
        end
    end
endmodule

// File: rtl/jtag_chain_host.sv
module jtag_chain_host
    import jtag_chain_host_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int HALF_DIV = 2,
    localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [1:0]          cmd_op,
    input  logic [LEN_W-1:0]    cmd_len,
    input  logic [MAX_BITS-1:0] cmd_data,
    output logic                rsp_valid,
    output logic [MAX_BITS-1:0] rsp_data,
    output logic                busy,
    output logic                scan_clk_o,
    output logic                scan_mode_o,
    output logic                scan_out_o,
    input  logic                scan_in_i
);
    localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BITS);
    localparam logic [2:0] RESET_LAST = 3'(RESET_CYCLES - 1);

    st_e                 state_q;
    logic [2:0]          step_q;
    logic [IDX_W-1:0]    idx_q;
    logic [LEN_W-1:0]    len_q;
    logic [MAX_BITS-1:0] pay_q;
    logic                is_ir_q;
    logic                at_reset_q;
    logic                sclk_q;
    logic                rsp_q;

    logic                tick;
    logic                rise_ev;
    logic                fall_ev;
    logic                last_bit;
    logic                accept;
    logic [LEN_W-1:0]    eff_len;
    logic [4:0]          walk_bits;
    logic [2:0]          walk_len;
    logic                mode_d;
    logic                out_d;

    assign accept   = cmd_valid && (state_q == ST_IDLE);
    assign rise_ev  = tick && !sclk_q;
    assign fall_ev  = tick && sclk_q;
    assign last_bit = (LEN_W'(idx_q) + LEN_W'(1)) == len_q;
    assign eff_len  = (cmd_len == '0)     ? LEN_W'(1) :
                      (cmd_len > LEN_MAX) ? LEN_MAX   : cmd_len;

    jtag_chain_host_div #(
        .HALF_DIV (HALF_DIV)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .tick  (tick)
    );

    jtag_chain_host_walk u_walk (
        .is_ir      (is_ir_q),
        .from_reset (at_reset_q),
        .walk_bits  (walk_bits),
        .walk_len   (walk_len)
    );

    jtag_chain_host_cap #(
        .MAX_BITS (MAX_BITS),
        .IDX_W    (IDX_W)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .sample (rise_ev && (state_q == ST_SHIFT)),
        .idx    (idx_q),
        .bit_in (scan_in_i),
        .data   (rsp_data)
    );

    // State register: every move after leaving idle happens on a falling scan edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            step_q     <= '0;
            idx_q      <= '0;
            len_q      <= '0;
            pay_q      <= '0;
            is_ir_q    <= 1'b0;
            at_reset_q <= 1'b0;
            sclk_q     <= 1'b0;
            rsp_q      <= 1'b0;
        end else begin
            rsp_q <= 1'b0;
            if (tick) begin
                sclk_q <= !sclk_q;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        pay_q   <= cmd_data;
                        len_q   <= eff_len;
                        is_ir_q <= (op_e'(cmd_op) == OP_IR);
                        step_q  <= '0;
                        idx_q   <= '0;
                        state_q <= (op_e'(cmd_op) == OP_RESET) ? ST_RESET : ST_ENTER;
                    end
                end
                ST_RESET: begin
                    if (fall_ev) begin
                        if (step_q == RESET_LAST) begin
                            state_q    <= ST_IDLE;
                            rsp_q      <= 1'b1;
                            at_reset_q <= 1'b1;
                        end else begin
                            step_q <= step_q + 3'd1;
                        end
                    end
                end
                ST_ENTER: begin
                    if (fall_ev) begin
                        if (step_q == walk_len - 3'd1) begin
                            state_q <= ST_SHIFT;
                            step_q  <= '0;
                        end else begin
                            step_q <= step_q + 3'd1;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (fall_ev) begin
                        if (last_bit) begin
                            state_q <= ST_EXIT;
                            step_q  <= '0;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                ST_EXIT: begin
                    if (fall_ev) begin
                        if (step_q == 3'd1) begin
                            state_q    <= ST_IDLE;
                            rsp_q      <= 1'b1;
                            at_reset_q <= 1'b0;
                        end else begin
                            step_q <= step_q + 3'd1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs: mode and serial data follow the registered state only.
    always_comb begin
        mode_d = 1'b0;
        out_d  = 1'b0;
        unique case (state_q)
            ST_IDLE:  mode_d = 1'b0;
            ST_RESET: mode_d = 1'b1;
            ST_ENTER: mode_d = walk_bits[step_q];
            ST_SHIFT: begin
                mode_d = last_bit;
                out_d  = pay_q[idx_q];
            end
            ST_EXIT:  mode_d = (step_q == 3'd0);
            default:  mode_d = 1'b0;
        endcase
    end

    assign scan_mode_o = mode_d;
    assign scan_out_o  = out_d;
    assign scan_clk_o  = sclk_q;
    assign busy        = (state_q != ST_IDLE);
    assign cmd_ready   = (state_q == ST_IDLE);
    assign rsp_valid   = rsp_q;
endmodule

// File: rtl/jtag_chain_host_chk.sv
module jtag_chain_host_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic busy,
    input logic rsp_valid,
    input logic scan_clk_o,
    input logic scan_mode_o,
    input logic scan_out_o
);
    // R1
    a_r1_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);

    // R1
    a_r1_busy_ends_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rsp_valid);

    // R1
    a_r1_rsp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    a_r2_clk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !scan_clk_o);

    // R3
    a_r3_mode_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scan_mode_o) |-> !scan_clk_o);

    // R3
    a_r3_out_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scan_out_o) |-> !scan_clk_o);

    // R3
    a_r3_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_clk_o) |-> ($stable(scan_mode_o) && $stable(scan_out_o)));
endmodule

bind jtag_chain_host jtag_chain_host_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .busy        (busy),
    .rsp_valid   (rsp_valid),
    .scan_clk_o  (scan_clk_o),
    .scan_mode_o (scan_mode_o),
    .scan_out_o  (scan_out_o)
);

// File: tb/jtag_chain_host_bench.sv
module jtag_chain_host_bench;
    localparam int MAX_BITS = 24;
    localparam int HALF_DIV = 3;
    localparam int LEN_W    = $clog2(MAX_BITS + 1);
    localparam int IR_LEN   = 15;
    localparam int DR_LEN   = 12;
    localparam logic [31:0] IR_CAP = 32'h0000_0401;
    localparam logic [31:0] DR_CAP = 32'h0000_05A3;
    localparam int NVEC = 11;

    // {op[1:0], len[7:0], payload[23:0]}
    localparam logic [33:0] VECS [NVEC] = '{
        {2'd0, 8'd0,  24'h000000},
        {2'd1, 8'd15, 24'h001002},
        {2'd2, 8'd12, 24'h000ABC},
        {2'd3, 8'd12, 24'h000123},
        {2'd1, 8'd20, 24'h0F1234},
        {2'd2, 8'd1,  24'h000001},
        {2'd1, 8'd24, 24'hC3A5F0},
        {2'd0, 8'd0,  24'h000000},
        {2'd2, 8'd5,  24'h000015},
        {2'd2, 8'd0,  24'h000001},
        {2'd1, 8'd31, 24'h5A5A5A}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cmd_valid = 1'b0;
    logic                cmd_ready;
    logic [1:0]          cmd_op = 2'd0;
    logic [LEN_W-1:0]    cmd_len = '0;
    logic [MAX_BITS-1:0] cmd_data = '0;
    logic                rsp_valid;
    logic [MAX_BITS-1:0] rsp_data;
    logic                busy;
    logic                sclk;
    logic                smode;
    logic                sout;
    logic                sin;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    jtag_chain_host #(
        .MAX_BITS (MAX_BITS),
        .HALF_DIV (HALF_DIV)
    ) u_jtag_chain_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_op      (cmd_op),
        .cmd_len     (cmd_len),
        .cmd_data    (cmd_data),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .busy        (busy),
        .scan_clk_o  (sclk),
        .scan_mode_o (smode),
        .scan_out_o  (sout),
        .scan_in_i   (sin)
    );

    // Two-device chain model: 5-bit and 10-bit IR, 12-bit DR.
    typedef enum logic [3:0] {
        T_TLR, T_RTI, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PADR, T_EX2DR,
        T_UPDR, T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PAIR, T_EX2IR, T_UPIR
    } tap_e;

    tap_e              tap_st = T_PADR;
    logic [IR_LEN-1:0] ir_sr = '0;
    logic [IR_LEN-1:0] ir_q = '0;
    logic [DR_LEN-1:0] dr_sr = '0;
    logic [DR_LEN-1:0] dr_q = '0;
    int                rises = 0;
    int                shifts = 0;
    logic              tdo_q = 1'b0;

    assign sin = tdo_q;

    function automatic tap_e tap_next(input tap_e s, input logic m);
        case (s)
            T_TLR:   return m ? T_TLR   : T_RTI;
            T_RTI:   return m ? T_SELDR : T_RTI;
            T_SELDR: return m ? T_SELIR : T_CAPDR;
            T_CAPDR: return m ? T_EX1DR : T_SHDR;
            T_SHDR:  return m ? T_EX1DR : T_SHDR;
            T_EX1DR: return m ? T_UPDR  : T_PADR;
            T_PADR:  return m ? T_EX2DR : T_PADR;
            T_EX2DR: return m ? T_UPDR  : T_SHDR;
            T_UPDR:  return m ? T_SELDR : T_RTI;
            T_SELIR: return m ? T_TLR   : T_CAPIR;
            T_CAPIR: return m ? T_EX1IR : T_SHIR;
            T_SHIR:  return m ? T_EX1IR : T_SHIR;
            T_EX1IR: return m ? T_UPIR  : T_PAIR;
            T_PAIR:  return m ? T_EX2IR : T_PAIR;
            T_EX2IR: return m ? T_UPIR  : T_SHIR;
            default: return m ? T_SELDR : T_RTI;
        endcase
    endfunction

    always @(posedge sclk) begin
        rises <= rises + 1;
        case (tap_st)
            T_TLR:   ir_q <= '1;
            T_CAPIR: ir_sr <= IR_CAP[IR_LEN-1:0];
            T_SHIR: begin
                ir_sr  <= {sout, ir_sr[IR_LEN-1:1]};
                shifts <= shifts + 1;
            end
            T_UPIR:  ir_q <= ir_sr;
            T_CAPDR: dr_sr <= DR_CAP[DR_LEN-1:0];
            T_SHDR: begin
                dr_sr  <= {sout, dr_sr[DR_LEN-1:1]};
                shifts <= shifts + 1;
            end
            T_UPDR:  dr_q <= dr_sr;
            default: ;
        endcase
        tap_st <= tap_next(tap_st, smode);
    end

    always @(negedge sclk) begin
        tdo_q <= (tap_st == T_SHIR) ? ir_sr[0] :
                 (tap_st == T_SHDR) ? dr_sr[0] : 1'b0;
    end

    // Phase-length (R2) and pin-steadiness (R3) monitor.
    int   cyc = 0;
    int   last_edge = 0;
    bit   have_edge = 0;
    int   hp_bad = 0;
    int   hp_seen = 0;
    int   r3_bad = 0;
    logic prev_sclk = 1'b0;
    logic prev_mode = 1'b0;
    logic prev_out = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (sclk !== prev_sclk) begin
                if (have_edge) begin
                    hp_seen <= hp_seen + 1;
                    if (cyc - last_edge != HALF_DIV) hp_bad <= hp_bad + 1;
                end
                last_edge <= cyc;
                have_edge <= busy;
            end else if (!busy) begin
                have_edge <= 1'b0;
            end
            if (sclk && ((smode !== prev_mode) || (sout !== prev_out))) r3_bad <= r3_bad + 1;
        end
        prev_sclk <= sclk;
        prev_mode <= smode;
        prev_out  <= sout;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rsp(input int l, input logic [31:0] c,
                                            input logic [31:0] p, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = (i < l) ? c[i] : p[i - l];
        return r;
    endfunction

    function automatic logic [31:0] exp_reg(input int l, input logic [31:0] c,
                                            input logic [31:0] p, input int n);
        logic [31:0] r = '0;
        for (int j = 0; j < l; j++) r[j] = (j + n < l) ? c[j + n] : p[j + n - l];
        return r;
    endfunction

    task automatic run_cmd(input logic [1:0] op, input int len, input logic [31:0] data,
                           input bit poke, output logic [31:0] rsp);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_len   = LEN_W'(len);
        cmd_data  = data[MAX_BITS-1:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R1 busy after accept", 32'(busy), 32'd1);
        if (poke) begin
            cmd_op    = 2'd0;
            cmd_valid = 1'b1;
            repeat (8) @(negedge clk);
            chk("R1 ready low while busy", 32'(cmd_ready), 32'd0);
            cmd_valid = 1'b0;
        end
        while (!rsp_valid) @(negedge clk);
        rsp = 32'(rsp_data);
        chk("R1 busy low with response", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R1 response is one pulse", 32'(rsp_valid), 32'd0);
    endtask

    bit at_tlr = 0;

    task automatic do_vec(input logic [1:0] op, input int len, input logic [31:0] data,
                          input bit poke);
        int          eff;
        int          r0;
        int          s0;
        int          l;
        int          nav;
        logic [31:0] c;
        logic [31:0] rsp;
        bit          is_ir;
        eff = (len == 0) ? 1 : (len > MAX_BITS) ? MAX_BITS : len;
        r0  = rises;
        s0  = shifts;
        run_cmd(op, len, data, poke, rsp);
        if (op == 2'd0) begin
            // R4: five mode-high cycles, chain in Test-Logic-Reset
            chk("R4 reset cycle count", 32'(rises - r0), 32'd5);
            chk("R4 chain in reset state", 32'(tap_st), 32'(T_TLR));
            chk("R4 reset response", rsp, 32'd0);
            at_tlr = 1;
        end else begin
            is_ir = (op == 2'd1);
            l     = is_ir ? IR_LEN : DR_LEN;
            c     = is_ir ? IR_CAP : DR_CAP;
            nav   = is_ir ? (at_tlr ? 5 : 4) : (at_tlr ? 4 : 3);
            chk(is_ir ? "R5 walk plus shift cycles" : "R6 walk plus shift cycles",
                32'(rises - r0), 32'(nav + eff + 2));
            chk((eff != len) ? "R11 clamped shift count" : "R7 shift count",
                32'(shifts - s0), 32'(eff));
            // R8 and, for over-length shifts, R10
            chk((eff > l) ? "R10 delayed payload in response" : "R8 response bits",
                rsp, exp_rsp(l, c, data, eff));
            chk("R7 chain register contents",
                is_ir ? 32'(ir_q) : 32'(dr_q), exp_reg(l, c, data, eff));
            chk("R9 parked in idle", 32'(tap_st), 32'(T_RTI));
            chk("R9 scan clock low", 32'(sclk), 32'd0);
            at_tlr = 0;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(cmd_ready), 32'd1);
        chk("R1 not busy after reset", 32'(busy), 32'd0);
        chk("R1 no response after reset", 32'(rsp_valid), 32'd0);
        chk("R2 scan clock low after reset", 32'(sclk), 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            do_vec(VECS[v][33:32], int'(VECS[v][31:24]), {8'h00, VECS[v][23:0]}, 1'b0);
        end

        // R1: a reset request offered while busy must not be taken
        do_vec(2'd2, 12, 32'h0000_00F0, 1'b1);
        do_vec(2'd1, 15, 32'h0000_7FFE, 1'b1);

        chk("R2 phase length", 32'(hp_bad), 32'd0);
        chk("R2 phases observed", 32'(hp_seen > 100), 32'd1);
        chk("R3 pins steady while scan clock high", 32'(r3_bad), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule